// File: doc/BRIEF.md
# Serial Disk Byte Transfer Interface

This block sits between a CPU register bus and a drive that moves data one bit at a time. A single shift register converts between the serial line and bytes. When the host writes, each byte it places in the write-data register is taken into the shifter when the previous byte has gone out. When the host reads, each finished byte is copied into the read-data register. One strobe from the drive moves one bit.

A single byte-ready flag paces both directions. The flag is set when eight bits have moved. It is cleared as a side effect of the host accessing the write-data, read-data or status register. The flag can also raise an interrupt. A control register sets the motor output, the transfer direction, the interrupt enable, and a transfer reset that puts the bit timing back to its start.

Top module: `sdx_byte_if`

## Requirements
- R1: After reset the flag, interrupt, motor output and serial output are 0. A status read returns 0 and a read-data read returns 0.
- R2: The motor output follows bit 0 of the last value written to the control register. It changes on the cycle after the write.
- R3: When control bit 2 is 1 (read mode), the block samples one bit from the serial input on each drive strobe, MSB first. On the eighth strobe the assembled byte goes into the read-data register, and the flag is set on the cycle after that strobe.
- R4: When control bit 2 is 0 (write mode), the serial output presents the MSB of the byte in the shifter and moves on by one bit per strobe. On the eighth strobe the shifter takes the write-data register and the flag is set.
- R5: While control bit 1 is 1, the bit count is held at 0, strobes are ignored and no flag is raised. In write mode the shifter keeps reloading from the write-data register during this time, so the first byte sent after release is that register's value.
- R6: The flag is cleared by a write to address 0, a read of address 2 and a read of address 3. A write to address 1 and reads of addresses 0 or 1 leave it unchanged.
- R7: If a byte completes in the same cycle as a clearing access, the flag stays set.
- R8: When control bit 7 is 1, the interrupt output rises together with the flag. It falls when the flag is cleared. With bit 7 at 0 the interrupt stays low.
- R9: The register map is: address 0 is write-data (write), 1 is control (write), 2 is status (read, flag in bit 1, all other bits 0), 3 is read-data (read). Reads of addresses 0 and 1 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_addr | input | 2 | Register address |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, combinational from the address |
| bit_strobe | input | 1 | One-cycle pulse from the drive, one per bit |
| ser_in | input | 1 | Serial data from the drive |
| ser_out | output | 1 | Serial data to the drive |
| motor_on | output | 1 | Motor enable |
| irq | output | 1 | Byte-ready interrupt |

## Verification
The bench goes after the eighth-strobe boundary in both directions. A counter off by one would raise the flag a strobe early or late, and a wrong bit order would scramble the random bytes. It checks that a transfer reset in the middle of a byte discards partial progress: if it did not, a byte would complete after fewer than eight new strobes. It makes a byte complete in the same cycle as a status read, where a design that let the clear win would lose a byte. It also confirms that the non-clearing accesses leave the flag set and that the interrupt stays low with its enable off.

// File: rtl/sdx_pkg.sv
package sdx_pkg;
    localparam logic [1:0] ADDR_WDATA = 2'd0;
    localparam logic [1:0] ADDR_CTRL  = 2'd1;
    localparam logic [1:0] ADDR_STAT  = 2'd2;
    localparam logic [1:0] ADDR_RDATA = 2'd3;

    localparam int CTRL_MOTOR_BIT = 0;
    localparam int CTRL_XRST_BIT  = 1;
    localparam int CTRL_DIR_BIT   = 2;
    localparam int CTRL_IEN_BIT   = 7;
    localparam int STAT_FLAG_BIT  = 1;

    typedef struct packed {
        logic ien;
        logic read_mode;
        logic xfer_rst;
        logic motor;
    } ctrl_t;
endpackage

// File: rtl/sdx_shifter.sv
module sdx_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic              ser_in,
    input  logic              xfer_rst,
    input  logic              read_mode,
    input  logic [DATA_W-1:0] load_val,
    output logic              byte_done,
    output logic [DATA_W-1:0] cap_val,
    output logic              ser_out
);
    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] sh;
    } sh_state_t;

    sh_state_t st_d, st_q;

    always_comb begin
        byte_done = strobe && !xfer_rst && (st_q.cnt == LAST);
        cap_val   = {st_q.sh[DATA_W-2:0], ser_in};
        st_d      = st_q;
        if (xfer_rst) begin
            st_d.cnt = '0;
            if (!read_mode) begin
                st_d.sh = load_val;
            end
        end else if (strobe) begin
            st_d.cnt = byte_done ? '0 : st_q.cnt + 1'b1;
            if (read_mode) begin
                st_d.sh = cap_val;
            end else if (byte_done) begin
                st_d.sh = load_val;
            end else begin
                st_d.sh = {st_q.sh[DATA_W-2:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ser_out = st_q.sh[DATA_W-1];
endmodule

// File: rtl/sdx_host_regs.sv
module sdx_host_regs
    import sdx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cpu_addr,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              byte_done,
    input  logic [DATA_W-1:0] cap_val,
    output ctrl_t             ctrl,
    output logic [DATA_W-1:0] wdata,
    output logic              flag,
    output logic              irq,
    output logic              clr_access
);
    typedef struct packed {
        ctrl_t             ctrl;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              flag;
        logic              irq;
    } reg_state_t;

    reg_state_t rs_d, rs_q;

    always_comb begin
        clr_access = (cpu_wr && cpu_addr == ADDR_WDATA)
                  || (cpu_rd && (cpu_addr == ADDR_STAT || cpu_addr == ADDR_RDATA));
        rs_d = rs_q;
        if (cpu_wr && cpu_addr == ADDR_WDATA) begin
            rs_d.wdata = cpu_wdata;
        end
        if (cpu_wr && cpu_addr == ADDR_CTRL) begin
            rs_d.ctrl.motor     = cpu_wdata[CTRL_MOTOR_BIT];
            rs_d.ctrl.xfer_rst  = cpu_wdata[CTRL_XRST_BIT];
            rs_d.ctrl.read_mode = cpu_wdata[CTRL_DIR_BIT];
            rs_d.ctrl.ien       = cpu_wdata[CTRL_IEN_BIT];
        end
        if (byte_done && rs_q.ctrl.read_mode) begin
            rs_d.rdata = cap_val;
        end
        if (byte_done) begin
            rs_d.flag = 1'b1;
            rs_d.irq  = rs_q.ctrl.ien ? 1'b1 : (clr_access ? 1'b0 : rs_q.irq);
        end else if (clr_access) begin
            rs_d.flag = 1'b0;
            rs_d.irq  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rs_q <= '0;
        end else begin
            rs_q <= rs_d;
        end
    end

    always_comb begin
        cpu_rdata = '0;
        if (cpu_addr == ADDR_STAT) begin
            cpu_rdata[STAT_FLAG_BIT] = rs_q.flag;
        end else if (cpu_addr == ADDR_RDATA) begin
            cpu_rdata = rs_q.rdata;
        end
    end

    assign ctrl  = rs_q.ctrl;
    assign wdata = rs_q.wdata;
    assign flag  = rs_q.flag;
    assign irq   = rs_q.irq;
endmodule

// File: rtl/sdx_byte_if.sv
module sdx_byte_if
    import sdx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cpu_addr,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              bit_strobe,
    input  logic              ser_in,
    output logic              ser_out,
    output logic              motor_on,
    output logic              irq
);
    ctrl_t             ctrl;
    logic [DATA_W-1:0] wdata;
    logic [DATA_W-1:0] cap_val;
    logic              byte_done;
    logic              flag;
    logic              clr_access;
    logic              xfer_rst;

    assign xfer_rst = ctrl.xfer_rst;
    assign motor_on = ctrl.motor;

    sdx_shifter #(.DATA_W(DATA_W)) shifter_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe    (bit_strobe),
        .ser_in    (ser_in),
        .xfer_rst  (xfer_rst),
        .read_mode (ctrl.read_mode),
        .load_val  (wdata),
        .byte_done (byte_done),
        .cap_val   (cap_val),
        .ser_out   (ser_out)
    );

    sdx_host_regs #(.DATA_W(DATA_W)) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_addr   (cpu_addr),
        .cpu_wr     (cpu_wr),
        .cpu_rd     (cpu_rd),
        .cpu_wdata  (cpu_wdata),
        .cpu_rdata  (cpu_rdata),
        .byte_done  (byte_done),
        .cap_val    (cap_val),
        .ctrl       (ctrl),
        .wdata      (wdata),
        .flag       (flag),
        .irq        (irq),
        .clr_access (clr_access)
    );
endmodule

// File: rtl/sdx_byte_if_chk.sv
module sdx_byte_if_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        cpu_addr,
    input logic              cpu_wr,
    input logic              cpu_rd,
    input logic [DATA_W-1:0] cpu_wdata,
    input logic [DATA_W-1:0] cpu_rdata,
    input logic              motor_on,
    input logic              irq,
    input logic              byte_done,
    input logic              clr_access,
    input logic              flag,
    input logic              xfer_rst
);
    assert_motor_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr == 2'd1) |=> (motor_on == $past(cpu_wdata[0])));

    assert_flag_after_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |=> flag);

    assert_no_flag_in_reset_R5: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_rst |-> !byte_done);

    assert_clear_on_access_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_access && !byte_done) |=> !flag);

    assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_access && byte_done) |=> flag);

    assert_irq_within_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag);

    assert_status_bits_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr == 2'd2) |-> (cpu_rdata[DATA_W-1:2] == '0 && cpu_rdata[0] == 1'b0));
endmodule

bind sdx_byte_if sdx_byte_if_chk #(.DATA_W(DATA_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_addr   (cpu_addr),
    .cpu_wr     (cpu_wr),
    .cpu_rd     (cpu_rd),
    .cpu_wdata  (cpu_wdata),
    .cpu_rdata  (cpu_rdata),
    .motor_on   (motor_on),
    .irq        (irq),
    .byte_done  (byte_done),
    .clr_access (clr_access),
    .flag       (flag),
    .xfer_rst   (xfer_rst)
);

// File: tb/sdx_byte_if_tb_top.sv
module sdx_byte_if_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cpu_addr = 2'd0;
    logic       cpu_wr = 1'b0;
    logic       cpu_rd = 1'b0;
    logic [7:0] cpu_wdata = 8'h00;
    logic [7:0] cpu_rdata;
    logic       bit_strobe = 1'b0;
    logic       ser_in = 1'b0;
    logic       ser_out;
    logic       motor_on;
    logic       irq;

    int n_checks = 0;
    int n_fail   = 0;
    logic [7:0] rd_v;

    always #10 clk = ~clk;

    sdx_byte_if #(.DATA_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
        .cpu_rd(cpu_rd), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .bit_strobe(bit_strobe), .ser_in(ser_in), .ser_out(ser_out),
        .motor_on(motor_on), .irq(irq)
    );

    function automatic logic [7:0] stat_exp(input logic f);
        return {6'b0, f, 1'b0};
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cpu_write(input logic [1:0] a, input logic [7:0] d);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic cpu_read(input logic [1:0] a, output logic [7:0] d);
        cpu_addr = a; cpu_rd = 1'b1;
        #1 d = cpu_rdata;
        @(negedge clk);
        cpu_rd = 1'b0;
    endtask

    task automatic strobe(input logic b);
        bit_strobe = 1'b1; ser_in = b;
        @(negedge clk);
        bit_strobe = 1'b0; ser_in = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5D1C0DE));
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 flag", dut_i.irq, 0);
        check("R1 motor", motor_on, 0);
        check("R1 ser_out", ser_out, 0);
        cpu_addr = 2'd2; #1 check("R1 status", cpu_rdata, 0);
        cpu_addr = 2'd3; #1 check("R1 rdata", cpu_rdata, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 motor
        cpu_write(2'd1, 8'h01);
        check("R2 motor on", motor_on, 1);
        cpu_write(2'd1, 8'h00);
        check("R2 motor off", motor_on, 0);

        // R9 reads of write-only addresses
        cpu_read(2'd0, rd_v); check("R9 addr0 read", rd_v, 0);
        cpu_read(2'd1, rd_v); check("R9 addr1 read", rd_v, 0);

        // R3 R8 read mode, random bytes with interrupt enabled
        cpu_write(2'd1, 8'h87);
        cpu_write(2'd1, 8'h85);
        for (int n = 0; n < 16; n++) begin
            logic [7:0] b;
            b = 8'($urandom);
            for (int i = 7; i >= 0; i--) begin
                strobe(b[i]);
                if (i == 1) check("R3 no early flag", irq, 0);
            end
            check("R8 irq with flag", irq, 1);
            cpu_read(2'd3, rd_v);
            check("R3 byte assembled", rd_v, b);
            check("R8 irq cleared", irq, 0);
            cpu_read(2'd2, rd_v);
            check("R6 rdata read clears", rd_v, stat_exp(1'b0));
        end

        // R5 reset mid-byte discards partial count
        for (int i = 0; i < 3; i++) strobe(1'b1);
        cpu_write(2'd1, 8'h07);
        for (int i = 0; i < 10; i++) strobe(1'b1);
        cpu_read(2'd2, rd_v); check("R5 no flag while held", rd_v, stat_exp(1'b0));
        cpu_write(2'd1, 8'h05);
        for (int i = 0; i < 7; i++) strobe(1'b0);
        cpu_read(2'd2, rd_v); check("R5 count restarted", rd_v, stat_exp(1'b0));
        strobe(1'b1);
        cpu_read(2'd3, rd_v); check("R5 byte after release", rd_v, 8'h01);

        // R6 non-clearing accesses, then R8 disabled
        cpu_write(2'd1, 8'h05);
        for (int i = 0; i < 8; i++) strobe(1'b0);
        check("R8 irq disabled", irq, 0);
        cpu_write(2'd1, 8'h05);
        cpu_read(2'd0, rd_v);
        cpu_read(2'd1, rd_v);
        cpu_read(2'd2, rd_v); check("R6 ctrl write and reads keep flag", rd_v, stat_exp(1'b1));
        for (int i = 0; i < 8; i++) strobe(1'b0);
        cpu_write(2'd0, 8'h00);
        cpu_read(2'd2, rd_v); check("R6 wdata write clears", rd_v, stat_exp(1'b0));

        // R7 completion coincides with status read
        for (int i = 0; i < 7; i++) strobe(1'b1);
        bit_strobe = 1'b1; ser_in = 1'b1; cpu_addr = 2'd2; cpu_rd = 1'b1;
        @(negedge clk);
        bit_strobe = 1'b0; cpu_rd = 1'b0;
        cpu_read(2'd2, rd_v); check("R7 set wins", rd_v, stat_exp(1'b1));

        // R4 R5 write mode, preload during reset
        begin
            logic [7:0] cur, nxt;
            cur = 8'($urandom);
            cpu_write(2'd1, 8'h03);
            cpu_write(2'd0, cur);
            cpu_write(2'd1, 8'h01);
            check("R5 preload first bit", ser_out, cur[7]);
            for (int n = 0; n < 16; n++) begin
                nxt = 8'($urandom);
                cpu_write(2'd0, nxt);
                for (int i = 7; i >= 0; i--) begin
                    check("R4 serial bit", ser_out, cur[i]);
                    strobe(1'b0);
                end
                cpu_read(2'd2, rd_v); check("R4 flag after byte", rd_v, stat_exp(1'b1));
                check("R4 next byte loaded", ser_out, nxt[7]);
                cur = nxt;
            end
        end

        finish_run();
    end
endmodule